// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps wall-clock time and the calendar date as seven packed-BCD byte fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A 32.768 kHz reference level is synchronised into the system clock domain. Its rising edges drive a binary prescaler, and the prescaler's wrap-around produces one advance tick per second. The tick ripples a carry through the fields. The carry takes account of the 12- or 24-hour format, the length of each month and leap years.

Software-side logic writes any field through a select/data write port. A write to the seconds field also clears the prescaler, so the next second begins at that moment. Reads go through a snapshot register. It captures all seven fields in a single cycle and holds them while counting continues. An update strobe follows every advance by one cycle, so alarm comparators can sample settled fields. A gated half-duty 1 Hz square wave and a registered copy of the reference are provided as derived clock outputs.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00 seconds, 00 minutes, hours 0x00 (24-hour midnight), day of week 1, date 0x01, month 0x01, year 0x00; `upd_o`, `hz_o` and `hz_oe` are 0.
- R2: Seconds and minutes count 00 to 59 in BCD; a seconds wrap from 0x59 to 0x00 advances minutes, and a minutes wrap advances hours.
- R3: With hours bit 6 clear, hours count 0x00 to 0x23 (bit 5 being the twenty digit); 0x23:59:59 wraps to 0x00:00:00 and advances the day.
- R4: With hours bit 6 set, bits 4:0 hold 01 to 12 and bit 5 is the PM flag; 11 flips PM and goes to 12, 12 goes to 01 without flipping; only the 11 PM to 12 AM step advances the day.
- R5: Day of week advances once per day and wraps from 7 to 1.
- R6: The date wraps to 0x01 after 0x30 in months 04, 06, 09 and 11, after 0x31 in the other months, and in month 02 after 0x29 when the year value is a multiple of 4, otherwise after 0x28.
- R7: A date wrap advances the month; month 0x12 wraps to 0x01 and advances the year, which wraps from 0x99 to 0x00.
- R8: Writes store data masked per field so unused bits read 0: seconds, minutes and hours keep bits 6:0, day of week bits 2:0, date bits 5:0, month bits 4:0, year all bits. Select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year; code 7 is ignored.
- R9: A seconds write clears the prescaler, so the next advance follows exactly 2^DIV_BITS further reference rising edges; writes to other fields leave the prescaler running.
- R10: `hz_oe` follows `hz_en`; while enabled `hz_o` is low in the first half of each second and high in the second half, and it is 0 while disabled; `ref_o` is the synchronised reference level.
- R11: `upd_o` is a one-cycle pulse in the cycle after each advance, and it does not pulse while the reference is idle.
- R12: `snap_take` copies all seven fields into `snap_o` ({year, month, date, dow, hours, minutes, seconds}, seconds in bits 7:0); `snap_o` holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_lvl | input | 1 | 32.768 kHz reference level (asynchronous) |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write data, packed BCD |
| snap_take | input | 1 | Capture all fields into the snapshot |
| hz_en | input | 1 | Enable for the 1 Hz output |
| snap_o | output | 56 | Snapshot of the seven fields |
| upd_o | output | 1 | One-cycle strobe after each advance |
| hz_o | output | 1 | 1 Hz square wave |
| hz_oe | output | 1 | Output enable for `hz_o` |
| ref_o | output | 1 | Registered copy of the reference |

## Verification
A wrong carry condition shows up at the ports within one advance. The first snapshot after a rollover second holds a wrong date, month or hour, so each boundary is staged one second before it happens. A prescaler fault does not change any field value. It shows only as a shift in which reference edge comes before `upd_o`, so the bench counts the reference edges it drives between a seconds write and the next strobe. A snapshot that leaks live state is caught when the bench lets seconds pass without a capture and then compares the snapshot.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int FIELD_W    = 8;
   localparam int NUM_FIELDS = 7;
   localparam int SEL_W      = 3;

   typedef logic [FIELD_W-1:0] bcd8_t;

   typedef enum logic [SEL_W-1:0] {
      F_SEC   = 3'd0,
      F_MIN   = 3'd1,
      F_HOUR  = 3'd2,
      F_DOW   = 3'd3,
      F_DATE  = 3'd4,
      F_MONTH = 3'd5,
      F_YEAR  = 3'd6
   } field_e;

   // one packed-BCD increment, no range limit
   function automatic bcd8_t bcd_next(bcd8_t v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   // bits that each field keeps on write
   function automatic bcd8_t write_mask(field_e f);
      case (f)
         F_SEC, F_MIN, F_HOUR: return 8'h7F;
         F_DOW:                return 8'h07;
         F_DATE:               return 8'h3F;
         F_MONTH:              return 8'h1F;
         default:              return 8'hFF;
      endcase
   endfunction

   // year multiple of 4, from the two BCD digits
   function automatic logic is_leap(bcd8_t y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic bcd8_t month_last(bcd8_t m, logic leap);
      case (m)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   // hour step in either format (bit 6 = 12-hour, bit 5 = PM or twenty digit)
   function automatic bcd8_t hour_next(bcd8_t h);
      bcd8_t t;
      if (h[6]) begin
         if (h[4:0] == 5'h12) return {2'b01, h[5], 5'h01};
         if (h[4:0] == 5'h11) return {2'b01, ~h[5], 5'h12};
         t = bcd_next({3'b000, h[4:0]});
         return {2'b01, h[5], t[4:0]};
      end
      if (h[5:0] == 6'h23) return 8'h00;
      return bcd_next({2'b00, h[5:0]});
   endfunction

   function automatic logic hour_rolls(bcd8_t h);
      if (h[6]) return h[5] && (h[4:0] == 5'h11);
      return h[5:0] == 6'h23;
   endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int DIV_BITS    = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_lvl,
   input  logic restart,
   output logic tick_o,
   output logic hz_sq_o,
   output logic ref_o
);
   localparam logic [DIV_BITS-1:0] DIV_TOP = '1;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("cal_prescaler: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [DIV_BITS-1:0]    div_q;
   logic                   ref_rise;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= ref_lvl;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign ref_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        div_q <= '0;
      else if (restart)  div_q <= '0;
      else if (ref_rise) div_q <= div_q + 1'b1;
   end

   assign tick_o  = ref_rise && (div_q == DIV_TOP) && !restart;
   assign hz_sq_o = div_q[DIV_BITS-1];
   assign ref_o   = sync_q[0];

   // R9: a restarted count cannot complete a second on the next cycle
   a_r9_no_tick_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick_o);
endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
   import cal_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  wr_sec,
   input  logic  wr_min,
   input  logic  wr_hour,
   input  bcd8_t wr_data,
   output bcd8_t sec_o,
   output bcd8_t min_o,
   output bcd8_t hour_o,
   output logic  day_inc_o
);
   bcd8_t sec_q, min_q, hour_q;
   logic  sec_wrap, min_wrap;

   assign sec_wrap  = tick && (sec_q == 8'h59);
   assign min_wrap  = sec_wrap && (min_q == 8'h59);
   assign day_inc_o = min_wrap && hour_rolls(hour_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= 8'h00;
         min_q  <= 8'h00;
         hour_q <= 8'h00;
      end else begin
         if (wr_sec)        sec_q <= wr_data & write_mask(F_SEC);
         else if (sec_wrap) sec_q <= 8'h00;
         else if (tick)     sec_q <= bcd_next(sec_q);

         if (wr_min)        min_q <= wr_data & write_mask(F_MIN);
         else if (min_wrap) min_q <= 8'h00;
         else if (sec_wrap) min_q <= bcd_next(min_q);

         if (wr_hour)       hour_q <= wr_data & write_mask(F_HOUR);
         else if (min_wrap) hour_q <= hour_next(hour_q);
      end
   end

   assign sec_o  = sec_q;
   assign min_o  = min_q;
   assign hour_o = hour_q;

   // R2: seconds wrap to zero
   a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_sec && sec_q == 8'h59) |=> (sec_q == 8'h00));
   // R3: 24-hour midnight
   a_r3_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_sec && !wr_min && !wr_hour && !hour_q[6] && hour_q[5:0] == 6'h23
       && min_q == 8'h59 && sec_q == 8'h59) |=> (hour_q == 8'h00));
   // R4: eleven o'clock flips the PM flag
   a_r4_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (min_wrap && !wr_hour && hour_q[6] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5])));
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
   import cal_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  day_inc,
   input  logic  wr_dow,
   input  logic  wr_date,
   input  logic  wr_month,
   input  logic  wr_year,
   input  bcd8_t wr_data,
   output bcd8_t dow_o,
   output bcd8_t date_o,
   output bcd8_t month_o,
   output bcd8_t year_o
);
   bcd8_t dow_q, date_q, month_q, year_q;
   logic  mon_inc, yr_inc;

   assign mon_inc = day_inc && (date_q == month_last(month_q, is_leap(year_q)));
   assign yr_inc  = mon_inc && (month_q == 8'h12);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dow_q   <= 8'h01;
         date_q  <= 8'h01;
         month_q <= 8'h01;
         year_q  <= 8'h00;
      end else begin
         if (wr_dow)       dow_q <= wr_data & write_mask(F_DOW);
         else if (day_inc) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;

         if (wr_date)      date_q <= wr_data & write_mask(F_DATE);
         else if (mon_inc) date_q <= 8'h01;
         else if (day_inc) date_q <= bcd_next(date_q);

         if (wr_month)     month_q <= wr_data & write_mask(F_MONTH);
         else if (yr_inc)  month_q <= 8'h01;
         else if (mon_inc) month_q <= bcd_next(month_q);

         if (wr_year)      year_q <= wr_data;
         else if (yr_inc)  year_q <= (year_q == 8'h99) ? 8'h00 : bcd_next(year_q);
      end
   end

   assign dow_o   = dow_q;
   assign date_o  = date_q;
   assign month_o = month_q;
   assign year_o  = year_q;

   // R5: week wraps back to day 1
   a_r5_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (day_inc && !wr_dow && dow_q == 8'h07) |=> (dow_q == 8'h01));
   // R6: date fields hold between days
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!day_inc && !wr_dow && !wr_date && !wr_month && !wr_year)
      |=> $stable({year_q, month_q, date_q, dow_q}));
   // R7: year wraps from 99
   a_r7_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (yr_inc && !wr_year && year_q == 8'h99) |=> (year_q == 8'h00));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import cal_pkg::*;
#(
   parameter int DIV_BITS    = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ref_lvl,
   input  logic                            wr_en,
   input  logic [SEL_W-1:0]                wr_sel,
   input  logic [FIELD_W-1:0]              wr_data,
   input  logic                            snap_take,
   input  logic                            hz_en,
   output logic [NUM_FIELDS*FIELD_W-1:0]   snap_o,
   output logic                            upd_o,
   output logic                            hz_o,
   output logic                            hz_oe,
   output logic                            ref_o
);
   localparam int SNAP_W = NUM_FIELDS * FIELD_W;
   localparam logic [SNAP_W-1:0] SNAP_RST = 56'h00_01_01_01_00_00_00;

   if (DIV_BITS < 2 || DIV_BITS > 24) begin : g_bad_div
      $error("bcd_calendar: DIV_BITS out of range 2..24");
   end

   logic [NUM_FIELDS-1:0] wr_hit;
   logic                  tick, hz_sq, day_inc;
   bcd8_t                 sec, min, hour, dow, date, month, year;
   logic [SNAP_W-1:0]     snap_q;
   logic                  upd_q;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_wdec
      assign wr_hit[g] = wr_en && (wr_sel == SEL_W'(g));
   end

   cal_prescaler #(.DIV_BITS(DIV_BITS), .SYNC_STAGES(SYNC_STAGES)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_lvl (ref_lvl),
      .restart (wr_hit[F_SEC]),
      .tick_o  (tick),
      .hz_sq_o (hz_sq),
      .ref_o   (ref_o)
   );

   cal_time_chain u_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_sec    (wr_hit[F_SEC]),
      .wr_min    (wr_hit[F_MIN]),
      .wr_hour   (wr_hit[F_HOUR]),
      .wr_data   (wr_data),
      .sec_o     (sec),
      .min_o     (min),
      .hour_o    (hour),
      .day_inc_o (day_inc)
   );

   cal_date_chain u_date (
      .clk      (clk),
      .rst_n    (rst_n),
      .day_inc  (day_inc),
      .wr_dow   (wr_hit[F_DOW]),
      .wr_date  (wr_hit[F_DATE]),
      .wr_month (wr_hit[F_MONTH]),
      .wr_year  (wr_hit[F_YEAR]),
      .wr_data  (wr_data),
      .dow_o    (dow),
      .date_o   (date),
      .month_o  (month),
      .year_o   (year)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q <= SNAP_RST;
         upd_q  <= 1'b0;
      end else begin
         if (snap_take) snap_q <= {year, month, date, dow, hour, min, sec};
         upd_q <= tick;
      end
   end

   assign snap_o = snap_q;
   assign upd_o  = upd_q;
   assign hz_oe  = hz_en;
   assign hz_o   = hz_en & hz_sq;

   // R11: the strobe is never two cycles wide
   a_r11_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |=> !upd_q);
   // R11: the strobe follows an advance
   a_r11_upd_follows: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> upd_q);
   // R12: the snapshot holds without a capture
   a_r12_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_take |=> $stable(snap_q));
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
   localparam int DIVB = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_lvl = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = 3'd0;
   logic [7:0]  wr_data = 8'h00;
   logic        snap_take = 1'b0;
   logic        hz_en = 1'b0;
   logic [55:0] snap_o;
   logic        upd_o, hz_o, hz_oe, ref_o;

   int checks = 0;
   int errors = 0;
   logic [55:0] exp_q[$];
   string       tag_q[$];

   logic ref_run = 1'b0;
   int   ref_half = 1;
   int   ph = 0;
   int   edge_cnt = 0;

   always #4 clk = ~clk;

   bcd_calendar #(.DIV_BITS(DIVB), .SYNC_STAGES(2)) u_bcd_calendar (
      .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .snap_take(snap_take),
      .hz_en(hz_en), .snap_o(snap_o), .upd_o(upd_o), .hz_o(hz_o),
      .hz_oe(hz_oe), .ref_o(ref_o)
   );

   // reference generator: counts the rising edges it drives
   initial begin
      forever begin
         @(negedge clk);
         if (ref_run) begin
            ph++;
            if (ph >= ref_half) begin
               ph = 0;
               ref_lvl = ~ref_lvl;
               if (ref_lvl) edge_cnt++;
            end
         end
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops expected snapshots and compares them
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            check(tag_q.pop_front(), {8'h00, snap_o}, {8'h00, exp_q.pop_front()});
         end
      end
   end

   function automatic logic [55:0] pk(input logic [7:0] y, mo, d, w, h, m, s);
      return {y, mo, d, w, h, m, s};
   endfunction

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] y, mo, d, w, h, m, s);
      wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd3, w);
      wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
   endtask

   // driver: capture and push the expected snapshot
   task automatic expect_snap(input logic [55:0] e, input string tag);
      @(negedge clk);
      snap_take = 1'b1;
      @(negedge clk);
      snap_take = 1'b0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic wait_upd();
      do @(negedge clk); while (!upd_o);
   endtask

   task automatic run_secs(input int n);
      ref_run = 1'b1;
      for (int i = 0; i < n; i++) wait_upd();
      ref_run = 1'b0;
   endtask

   task automatic step_case(input logic [55:0] start, input logic [55:0] after, input string tag);
      set_time(start[55:48], start[47:40], start[39:32], start[31:24],
               start[23:16], start[15:8], start[7:0]);
      run_secs(1);
      expect_snap(after, tag);
   endtask

   initial begin
      #1200000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [55:0] held;
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 snapshot", {8'h00, snap_o}, {8'h00, pk(8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h00)});
      check("R1 upd", {63'd0, upd_o}, 64'd0);
      check("R1 hz", {62'd0, hz_o, hz_oe}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      expect_snap(pk(8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h00), "R1 live fields");

      // R2 seconds and minutes
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h00,8'h00,8'h58),
                pk(8'h23,8'h05,8'h10,8'h03,8'h00,8'h00,8'h59), "R2 58->59");
      run_secs(1);
      expect_snap(pk(8'h23,8'h05,8'h10,8'h03,8'h00,8'h01,8'h00), "R2 minute carry");
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h00,8'h59,8'h59),
                pk(8'h23,8'h05,8'h10,8'h03,8'h01,8'h00,8'h00), "R2 hour carry");
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h09,8'h59,8'h59),
                pk(8'h23,8'h05,8'h10,8'h03,8'h10,8'h00,8'h00), "R2 BCD hour digit");

      // R3 24-hour midnight
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h23,8'h59,8'h59),
                pk(8'h23,8'h05,8'h11,8'h04,8'h00,8'h00,8'h00), "R3 midnight");
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h19,8'h59,8'h59),
                pk(8'h23,8'h05,8'h10,8'h03,8'h20,8'h00,8'h00), "R3 twenty digit");

      // R4 12-hour sequence
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h51,8'h59,8'h59),
                pk(8'h23,8'h05,8'h10,8'h03,8'h72,8'h00,8'h00), "R4 11AM->12PM");
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h72,8'h59,8'h59),
                pk(8'h23,8'h05,8'h10,8'h03,8'h61,8'h00,8'h00), "R4 12PM->1PM");
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h71,8'h59,8'h59),
                pk(8'h23,8'h05,8'h11,8'h04,8'h52,8'h00,8'h00), "R4 11PM->12AM");
      step_case(pk(8'h23,8'h05,8'h10,8'h03,8'h52,8'h59,8'h59),
                pk(8'h23,8'h05,8'h10,8'h03,8'h41,8'h00,8'h00), "R4 12AM->1AM");

      // R5 week wrap
      step_case(pk(8'h23,8'h05,8'h10,8'h07,8'h23,8'h59,8'h59),
                pk(8'h23,8'h05,8'h11,8'h01,8'h00,8'h00,8'h00), "R5 dow 7->1");

      // R6 month lengths
      step_case(pk(8'h23,8'h04,8'h30,8'h02,8'h23,8'h59,8'h59),
                pk(8'h23,8'h05,8'h01,8'h03,8'h00,8'h00,8'h00), "R6 30-day month");
      step_case(pk(8'h23,8'h01,8'h30,8'h02,8'h23,8'h59,8'h59),
                pk(8'h23,8'h01,8'h31,8'h03,8'h00,8'h00,8'h00), "R6 31-day month");
      step_case(pk(8'h23,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59),
                pk(8'h23,8'h03,8'h01,8'h03,8'h00,8'h00,8'h00), "R6 Feb common");
      step_case(pk(8'h24,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59),
                pk(8'h24,8'h02,8'h29,8'h03,8'h00,8'h00,8'h00), "R6 Feb leap 24");
      step_case(pk(8'h24,8'h02,8'h29,8'h02,8'h23,8'h59,8'h59),
                pk(8'h24,8'h03,8'h01,8'h03,8'h00,8'h00,8'h00), "R6 Feb 29 end");
      step_case(pk(8'h00,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59),
                pk(8'h00,8'h02,8'h29,8'h03,8'h00,8'h00,8'h00), "R6 Feb leap 00");
      step_case(pk(8'h10,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59),
                pk(8'h10,8'h03,8'h01,8'h03,8'h00,8'h00,8'h00), "R6 Feb common 10");
      step_case(pk(8'h12,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59),
                pk(8'h12,8'h02,8'h29,8'h03,8'h00,8'h00,8'h00), "R6 Feb leap 12");
      step_case(pk(8'h23,8'h11,8'h30,8'h02,8'h23,8'h59,8'h59),
                pk(8'h23,8'h12,8'h01,8'h03,8'h00,8'h00,8'h00), "R6 November end");

      // R7 year wrap
      step_case(pk(8'h99,8'h12,8'h31,8'h05,8'h23,8'h59,8'h59),
                pk(8'h00,8'h01,8'h01,8'h06,8'h00,8'h00,8'h00), "R7 year 99->00");
      step_case(pk(8'h19,8'h12,8'h31,8'h05,8'h23,8'h59,8'h59),
                pk(8'h20,8'h01,8'h01,8'h06,8'h00,8'h00,8'h00), "R7 year BCD carry");

      // R8 write masks, select 7 ignored
      set_time(8'hA5, 8'hE9, 8'hF1, 8'hFD, 8'hC5, 8'hBB, 8'hFF);
      wr(3'd7, 8'h00);
      expect_snap(pk(8'hA5,8'h09,8'h31,8'h05,8'h45,8'h3B,8'h7F), "R8 masked writes");

      // R10 reference copy and 1 Hz enable
      ref_lvl = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 ref_o high", {63'd0, ref_o}, 64'd1);
      ref_lvl = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 ref_o low", {63'd0, ref_o}, 64'd0);
      check("R10 hz disabled", {62'd0, hz_o, hz_oe}, 64'd0);
      hz_en = 1'b1;
      @(negedge clk);
      check("R10 hz_oe", {63'd0, hz_oe}, 64'd1);

      // R9 prescaler restart, slower reference
      ref_half = 4;
      ph = 0;
      set_time(8'h23,8'h05,8'h10,8'h03,8'h00,8'h00,8'h00);
      edge_cnt = 0;
      ref_run = 1'b1;
      wait_upd();
      check("R9 edges after seconds write", edge_cnt, 8);
      check("R10 hz low at second start", {63'd0, hz_o}, 64'd0);
      @(negedge clk);
      check("R11 upd one cycle", {63'd0, upd_o}, 64'd0);
      while (edge_cnt < 12) @(negedge clk);
      repeat (4) @(negedge clk);
      check("R10 hz high in second half", {63'd0, hz_o}, 64'd1);
      wr(3'd1, 8'h30);
      wait_upd();
      check("R9 minutes write keeps count", edge_cnt, 16);
      while (edge_cnt < 19) @(negedge clk);
      repeat (3) @(negedge clk);
      wr(3'd0, 8'h10);
      wait_upd();
      check("R9 mid-second restart", edge_cnt, 27);
      ref_run = 1'b0;
      ref_half = 1;

      // R11 no strobe while the reference is idle
      begin
         int seen = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (upd_o) seen++;
         end
         check("R11 idle no strobe", seen, 0);
      end

      // R12 snapshot holds while time advances
      set_time(8'h23,8'h05,8'h10,8'h03,8'h08,8'h00,8'h10);
      expect_snap(pk(8'h23,8'h05,8'h10,8'h03,8'h08,8'h00,8'h10), "R12 capture");
      held = snap_o;
      run_secs(2);
      repeat (2) @(negedge clk);
      check("R12 held", {8'h00, snap_o}, {8'h00, held});
      expect_snap(pk(8'h23,8'h05,8'h10,8'h03,8'h08,8'h00,8'h12), "R12 recapture");

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule